// File: doc/BRIEF.md
# Priority Interrupt Controller with Level Mask

This block sits between eight interrupt sources and a processor. Each source raises an active-high request line. The block captures requests in a sticky pending register and picks the highest-numbered pending level. It raises a single interrupt request towards the processor only when two conditions hold. First, the processor's interrupt-enable flag has been armed. Second, the chosen level lies strictly above a programmable current-level mask, unless the mask is set to admit every level.

When the processor acknowledges, the block places a restart opcode on an 8-bit bus. That opcode jumps to one of eight vectors in low memory, spaced eight bytes apart. The acknowledge line is the only handshake on the opcode bus. The processor reads the opcode while the acknowledge is high, and the block holds that opcode stable for as long as the acknowledge stays high. The bus has no back-pressure; the processor sets the pace.

After each grant the block disarms itself, and software must pulse the enable input before the next request can be forwarded. Decoding of register writes, cascading several controllers and the processor itself are outside the block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A synchronous reset clears every pending bit, drives `intr_o` low and `vec_o` to 0, disarms the enable flag, and sets the mask to admit all levels.
- R2: Request lines are sampled into the pending register on every clock edge. With the block armed and the level admitted, `intr_o` goes high on the second rising edge after a request appears, and not on the first.
- R3: Level 7 is the highest priority and level 0 the lowest. On acknowledge, `vec_o` equals 8'b11_nnn_111, which is 0xC7 + 8*n, where n is the highest qualifying pending level.
- R4: A pulse on `lvl_wr_i` loads `lvl_wr_lvl_i` and `lvl_wr_all_i`. While the all flag is 0, only pending levels strictly greater than the loaded level qualify.
- R5: While the all flag is 1, every pending level qualifies, whatever level is stored.
- R6: Nothing is forwarded while the enable flag is disarmed. A one-cycle pulse on `ie_set_i` arms it. A grant disarms it, and a later pulse is needed before `intr_o` can rise again.
- R7: Once high, `intr_o` stays high until the acknowledge is seen. While it waits, a newly arriving higher qualifying request replaces the level that will be granted.
- R8: While `inta_i` stays high after a grant, `vec_o` holds its value, even if a higher request arrives.
- R9: A pending bit is cleared only when its level is granted. A request that has been withdrawn stays pending until it is serviced.
- R10: An acknowledge that arrives while `intr_o` is low is ignored. `vec_o` stays 0 and no pending bit is cleared.
- R11: `vec_o` is 0 whenever `inta_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_req_i | input | 8 | Interrupt request lines, bit n is level n |
| lvl_wr_i | input | 1 | Mask write strobe |
| lvl_wr_lvl_i | input | 3 | Current level to load |
| lvl_wr_all_i | input | 1 | 1 = admit every level |
| ie_set_i | input | 1 | One-cycle pulse that arms the enable flag |
| inta_i | input | 1 | Acknowledge from the processor |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Restart opcode while acknowledged, otherwise 0 |

## Verification
The hardest case to reach is a grant whose level changes after `intr_o` has already risen, followed by a still higher request that lands in the middle of the acknowledge. The stimulus raises a mid-level request and holds off the acknowledge for many cycles. It then pulses a higher request and checks that the opcode follows it. While the acknowledge is still held, it injects level 7 and checks that the opcode stays frozen. The bench then re-arms the block twice to show that the late level-7 request and the withdrawn original request are each serviced in turn. An exhaustive sweep covers every nonzero request pattern against all nine mask settings.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam int unsigned LVL_COUNT = 8;
  localparam int unsigned LVL_BITS  = $clog2(LVL_COUNT);

  typedef logic [LVL_BITS-1:0] lvl_t;

  // restart opcode: 11 nnn 111, vector at nnn*8
  function automatic logic [7:0] rst_opcode(input lvl_t lvl);
    return {2'b11, lvl, 3'b111};
  endfunction

endpackage

// File: rtl/prio_irq_pending.sv
module prio_irq_pending #(
  parameter int unsigned N_LVL = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_LVL-1:0] req_i,
  input  logic [N_LVL-1:0] clr_i,
  output logic [N_LVL-1:0] pend_o
);

  logic [N_LVL-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_i) | req_i;
  end

  assign pend_o = pend_q;

  p_single_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_i));

  for (genvar i = 0; i < N_LVL; i++) begin : g_bit
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      pend_q[i] && !clr_i[i] |=> pend_q[i]);
    p_cleared_r9: assert property (@(posedge clk) disable iff (rst)
      clr_i[i] && !req_i[i] |=> !pend_q[i]);
  end

endmodule

// File: rtl/prio_irq_select.sv
module prio_irq_select #(
  parameter int unsigned N_LVL = 8,
  localparam int unsigned LW   = $clog2(N_LVL)
) (
  input  logic [N_LVL-1:0] pend_i,
  input  logic             all_i,
  input  logic [LW-1:0]    lvl_i,
  output logic             any_o,
  output logic [LW-1:0]    best_o
);

  logic [N_LVL-1:0] qual;

  for (genvar i = 0; i < N_LVL; i++) begin : g_qual
    localparam logic [LW-1:0] IDX = LW'(i);
    assign qual[i] = pend_i[i] & (all_i | (IDX > lvl_i));
  end

  always_comb begin
    any_o  = 1'b0;
    best_o = '0;
    for (int i = 0; i < N_LVL; i++) begin
      if (qual[i]) begin
        any_o  = 1'b1;
        best_o = LW'(i);
      end
    end
  end

endmodule

// File: rtl/prio_irq_handshake.sv
module prio_irq_handshake #(
  parameter int unsigned N_LVL = 8,
  localparam int unsigned LW   = $clog2(N_LVL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ie_set_i,
  input  logic          any_i,
  input  logic [LW-1:0] best_i,
  input  logic          inta_i,
  output logic          intr_o,
  output logic [LW-1:0] lvl_o,
  output logic          gnt_o,
  output logic          act_o
);

  logic          en_q, intr_q, act_q;
  logic [LW-1:0] lvl_q;
  logic          gnt, start, track;

  assign gnt   = inta_i & intr_q;
  assign start = !intr_q && !act_q && en_q && any_i && !inta_i;
  assign track = !inta_i && !act_q && any_i && (intr_q || start);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      intr_q <= 1'b0;
      act_q  <= 1'b0;
      lvl_q  <= '0;
    end else begin
      if (gnt)           en_q <= 1'b0;
      else if (ie_set_i) en_q <= 1'b1;

      if (gnt)        intr_q <= 1'b0;
      else if (start) intr_q <= 1'b1;

      if (gnt)          act_q <= 1'b1;
      else if (!inta_i) act_q <= 1'b0;

      if (track) lvl_q <= best_i;
    end
  end

  assign intr_o = intr_q;
  assign lvl_o  = lvl_q;
  assign gnt_o  = gnt;
  assign act_o  = inta_i & (intr_q | act_q);

  p_armed_before_intr_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(intr_q) |-> $past(en_q));
  p_disarm_on_grant_r6: assert property (@(posedge clk) disable iff (rst)
    gnt |=> !en_q && !intr_q);
  p_intr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    intr_q && !inta_i |=> intr_q);
  p_level_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    act_q && inta_i |-> $stable(lvl_q));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_LVL = LVL_COUNT,
  localparam int unsigned LW   = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_LVL-1:0] irq_req_i,
  input  logic             lvl_wr_i,
  input  logic [LW-1:0]    lvl_wr_lvl_i,
  input  logic             lvl_wr_all_i,
  input  logic             ie_set_i,
  input  logic             inta_i,
  output logic             intr_o,
  output logic [7:0]       vec_o
);

  logic             all_q;
  logic [LW-1:0]    mlvl_q;
  logic [N_LVL-1:0] pend, clr;
  logic             any, gnt, act;
  logic [LW-1:0]    best, glvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      all_q  <= 1'b1;
      mlvl_q <= '0;
    end else if (lvl_wr_i) begin
      all_q  <= lvl_wr_all_i;
      mlvl_q <= lvl_wr_lvl_i;
    end
  end

  prio_irq_pending #(.N_LVL(N_LVL)) u_pending (
    .clk    (clk),
    .rst    (rst),
    .req_i  (irq_req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  prio_irq_select #(.N_LVL(N_LVL)) u_select (
    .pend_i (pend),
    .all_i  (all_q),
    .lvl_i  (mlvl_q),
    .any_o  (any),
    .best_o (best)
  );

  prio_irq_handshake #(.N_LVL(N_LVL)) u_hs (
    .clk      (clk),
    .rst      (rst),
    .ie_set_i (ie_set_i),
    .any_i    (any),
    .best_i   (best),
    .inta_i   (inta_i),
    .intr_o   (intr_o),
    .lvl_o    (glvl),
    .gnt_o    (gnt),
    .act_o    (act)
  );

  assign clr   = gnt ? ({{(N_LVL-1){1'b0}}, 1'b1} << glvl) : '0;
  assign vec_o = act ? rst_opcode(lvl_t'(glvl)) : 8'h00;

  p_vec_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !inta_i |-> vec_o == 8'h00);
  p_vec_format_r3: assert property (@(posedge clk) disable iff (rst)
    vec_o != 8'h00 |-> vec_o[7:6] == 2'b11 && vec_o[2:0] == 3'b111);
  p_stray_ack_r10: assert property (@(posedge clk) disable iff (rst)
    inta_i && !$past(inta_i) && !intr_o |-> vec_o == 8'h00);

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq = '0;
  logic       lvl_wr = 1'b0;
  logic [2:0] lvl_val = '0;
  logic       lvl_all = 1'b0;
  logic       ie_set = 1'b0;
  logic       inta = 1'b0;
  logic       intr;
  logic [7:0] vec;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk          (clk),
    .rst          (rst),
    .irq_req_i    (irq),
    .lvl_wr_i     (lvl_wr),
    .lvl_wr_lvl_i (lvl_val),
    .lvl_wr_all_i (lvl_all),
    .ie_set_i     (ie_set),
    .inta_i       (inta),
    .intr_o       (intr),
    .vec_o        (vec)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    step();
    rst = 1'b1; irq = '0; lvl_wr = 1'b0; ie_set = 1'b0; inta = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic arm();
    ie_set = 1'b1; step(); ie_set = 1'b0;
  endtask

  function automatic int opc(input int lvl);
    return 8'hC7 + 8 * lvl;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state and R6 no forwarding while disarmed
    do_reset();
    check("R1 intr after reset", intr, 0);
    check("R1 vec after reset", vec, 0);
    irq = 8'h80; step(); irq = '0;
    step(4);
    check("R6 disarmed blocks intr", intr, 0);
    arm(); step();
    check("R9 withdrawn request still pending", intr, 1);

    // R2 latency
    do_reset();
    ie_set = 1'b1; irq = 8'h10; step();
    ie_set = 1'b0; irq = '0;
    check("R2 intr not after first edge", intr, 0);
    step();
    check("R2 intr after second edge", intr, 1);

    // R7 hold and retarget, R8 freeze, R6 re-arm, R9 later service
    step(20);
    check("R7 intr held without ack", intr, 1);
    irq = 8'h40; step(); irq = '0; step(2);
    inta = 1'b1; #1;
    check("R7 higher arrival retargets", vec, opc(6));
    step();
    irq = 8'h80; #1;
    check("R8 opcode held in ack", vec, opc(6));
    step(); irq = '0; #1;
    check("R8 opcode held after new request", vec, opc(6));
    inta = 1'b0; step();
    check("R6 intr low after grant", intr, 0);
    step(3);
    check("R6 stays low until re-armed", intr, 0);
    arm(); step();
    check("R6 re-armed forwards", intr, 1);
    inta = 1'b1; #1;
    check("R3 level 7 opcode", vec, opc(7));
    step(); inta = 1'b0; step();
    arm(); step(2);
    inta = 1'b1; #1;
    check("R9 withdrawn level 4 served", vec, opc(4));
    step(); inta = 1'b0; step(); #1;
    check("R11 vec zero after ack", vec, 0);

    // R10 stray acknowledge
    do_reset();
    arm();
    inta = 1'b1; #1;
    check("R10 stray ack vec", vec, 0);
    step(); inta = 1'b0; step();
    check("R10 stray ack intr", intr, 0);
    irq = 8'h01; step(); irq = '0; step(2);
    check("R10 later request forwarded", intr, 1);
    inta = 1'b1; #1;
    check("R3 level 0 opcode", vec, opc(0));
    step(); inta = 1'b0; step();

    // R3 R4 R5 sweep over every pattern and every mask setting
    for (int m = 0; m <= 8; m++) begin
      for (int p = 1; p < 256; p++) begin
        int hi;
        int exp_lvl;
        do_reset();
        if (m < 8) begin
          lvl_wr = 1'b1; lvl_val = 3'(m); lvl_all = 1'b0;
          step(); lvl_wr = 1'b0;
        end
        hi = 0;
        for (int b = 0; b < 8; b++) if (p[b]) hi = b;
        exp_lvl = (m == 8 || hi > m) ? hi : -1;
        ie_set = 1'b1; irq = 8'(p); step();
        ie_set = 1'b0; irq = '0; step(3);
        check(m == 8 ? "R5 intr all levels" : "R4 intr vs mask", intr, exp_lvl >= 0 ? 1 : 0);
        inta = 1'b1; #1;
        check("R3 opcode of highest qualifying", vec, exp_lvl >= 0 ? opc(exp_lvl) : 0);
        step(); inta = 1'b0; step();
        check("R6 intr low after ack", intr, 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule